// File: doc/BRIEF.md
# RTC Dual Alarm Comparator

This block watches the running time-of-day and calendar fields of a real-time clock and compares them against two independent alarm register sets. Each alarm byte holds a BCD value in its low seven bits and a field-enable flag in bit 7, so an alarm can match on any one field, any group of fields or all six (seconds, minutes, hours, date, month, day-of-week). The comparison is made only in the cycle where the clock source raises its one-cycle `tick` update marker, so a single matching instant yields exactly one alarm event even though the fields stay equal for many cycles.

A small register port writes the alarm bytes, the per-alarm arm bits, a mode bit and an auto-clear bit, and reads them back along with two status flags. Both alarms drive one shared active-low interrupt line. In single-event mode a match latches its status flag and holds the line low until both flags are cleared, either by writing zero to a flag or, with auto-clear armed, by a status read. In periodic mode every match drives the line low for a fixed number of cycles set by a parameter, independent of the flags.

The interrupt line is produced by a three-state machine: `ST_IDLE` (line high), `ST_HELD` (single-event latch, line low) and `ST_PULSE` (periodic pulse, line low). Transitions: `ST_IDLE` to `ST_PULSE` on a match in periodic mode; `ST_IDLE` to `ST_HELD` when any flag is set in single-event mode; `ST_HELD` to `ST_IDLE` when both flags clear or the mode turns periodic (to `ST_PULSE` instead if a match arrives in that cycle); `ST_PULSE` reloads its width counter on a new match and returns to `ST_IDLE` when the counter reaches zero.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset all alarm bytes, the control register and both flags are 0, `irq_n` is 1, and every register address reads 0.
- R2: Addresses 0 to 5 hold alarm 0 seconds, minutes, hours, date, month, day-of-week; 6 to 11 hold the same for alarm 1; address 12 is control (bit 0 arms alarm 0, bit 1 arms alarm 1, bit 2 selects periodic mode, bit 3 enables auto-clear, bits 7:4 read 0); address 13 is status (bit 0 flag of alarm 0, bit 1 flag of alarm 1); addresses 14 and 15 read 0. `rdata` shows the addressed register combinationally.
- R3: An alarm matches when every field whose byte has bit 7 set has bits 6:0 equal to the RTC field. Matches are taken only in a cycle with `tick` high; the flag is set at the clock edge that ends that cycle.
- R4: An alarm whose arm bit is 0, or whose six field-enable bits are all 0, never sets its flag.
- R5: In single-event mode `irq_n` goes low at the same edge a flag is set and stays low until both flags are 0, returning high at the edge that clears the last one.
- R6: Writing status clears each flag whose written bit (bit 0 or bit 1) is 0; writing 1 leaves the flag unchanged and never sets it.
- R7: A cycle with `rd_en` high at the status address clears both flags at its closing edge when auto-clear is 1, and leaves them unchanged when it is 0.
- R8: A match arriving in the same cycle as a clear (write or auto-clear) leaves that flag set.
- R9: In periodic mode each matching tick drives `irq_n` low for exactly PULSE_W cycles starting at the edge after the tick, whatever the flags hold; a match during a pulse restarts the full width. Flags are still set by matches in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle marker of an RTC update |
| rtc_sec | input | 7 | Current seconds, BCD |
| rtc_min | input | 7 | Current minutes, BCD |
| rtc_hour | input | 7 | Current hours, BCD |
| rtc_date | input | 7 | Current day of month, BCD |
| rtc_month | input | 7 | Current month, BCD |
| rtc_dow | input | 7 | Current day of week, BCD |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives auto-clear) |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| alm_flags | output | 2 | Alarm status flags, bit 0 alarm 0 |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
Flags and `irq_n` change at the first clock edge after the tick, write or read cycle that causes them, so the bench drives inputs after a falling edge and samples after the next falling edge, one edge later. Readback through `rdata` has no latency and is sampled in the same half cycle the address is applied. Periodic pulses are measured by counting consecutive low samples, one per cycle, from the first edge after the tick until `irq_n` returns high, and comparing the count with PULSE_W (or PULSE_W plus the restart offset).

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
    localparam int NUM_FIELDS = 6;   // sec, min, hour, date, month, dow
    localparam int NUM_ALARMS = 2;
    localparam int NUM_ALM_REGS = NUM_FIELDS * NUM_ALARMS;
    localparam int REG_CTRL = NUM_ALM_REGS;
    localparam int REG_STAT = NUM_ALM_REGS + 1;
    localparam int CTRL_W = NUM_ALARMS + 2;
    localparam int BIT_PERIODIC = NUM_ALARMS;
    localparam int BIT_AUTOCLR = NUM_ALARMS + 1;
    localparam int FIELD_EN_BIT = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_PULSE = 2'd2
    } irq_state_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
    import rtc_alarm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][7:0] alarm_bytes,
    input  logic [NUM_FIELDS-1:0][6:0] rtc_fields,
    input  logic                       armed,
    output logic                       hit
);
    logic [NUM_FIELDS-1:0] field_ok;
    logic [NUM_FIELDS-1:0] field_en;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign field_en[f] = alarm_bytes[f][FIELD_EN_BIT];
        assign field_ok[f] = !field_en[f] || (alarm_bytes[f][6:0] == rtc_fields[f]);
    end

    assign hit = armed && (|field_en) && (&field_ok);
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic                                  rd_en,
    input  logic [ADDR_W-1:0]                     addr,
    input  logic [7:0]                            wdata,
    input  logic [NUM_ALARMS-1:0]                 set_evt,
    output logic [7:0]                            rdata,
    output logic [NUM_ALARMS-1:0][NUM_FIELDS-1:0][7:0] alarm_bytes,
    output logic [CTRL_W-1:0]                     ctrl,
    output logic [NUM_ALARMS-1:0]                 flags,
    output logic [NUM_ALARMS-1:0]                 flags_nxt
);
    logic [NUM_ALM_REGS-1:0][7:0] alm_q;
    logic [NUM_ALARMS-1:0]        clr_mask;
    logic                         hit_ctrl, hit_stat;

    assign hit_ctrl = (addr == ADDR_W'(REG_CTRL));
    assign hit_stat = (addr == ADDR_W'(REG_STAT));

    for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alarm
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_byte
            assign alarm_bytes[k][f] = alm_q[k*NUM_FIELDS + f];
        end
    end

    always_comb begin
        clr_mask = '0;
        if (wr_en && hit_stat)
            clr_mask = ~wdata[NUM_ALARMS-1:0];
        if (rd_en && hit_stat && ctrl[BIT_AUTOCLR])
            clr_mask = '1;
        flags_nxt = (flags & ~clr_mask) | set_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alm_q <= '0;
            ctrl  <= '0;
            flags <= '0;
        end else begin
            flags <= flags_nxt;
            if (wr_en && (int'(addr) < NUM_ALM_REGS))
                alm_q[addr] <= wdata;
            if (wr_en && hit_ctrl)
                ctrl <= wdata[CTRL_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(addr) < NUM_ALM_REGS)
            rdata = alm_q[addr];
        else if (hit_ctrl)
            rdata = 8'(ctrl);
        else if (hit_stat)
            rdata = 8'(flags);
    end
endmodule

// File: rtl/alarm_irq_fsm.sv
module alarm_irq_fsm
    import rtc_alarm_pkg::*;
#(
    parameter int PULSE_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_periodic,
    input  logic                  ev_any,
    input  logic [NUM_ALARMS-1:0] flags_nxt,
    output logic                  irq_n
);
    localparam int CNT_W = $clog2(PULSE_W + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_W - 1);

    irq_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (mode_periodic && ev_any) begin
                    state_nxt = ST_PULSE;
                    cnt_nxt   = CNT_LOAD;
                end else if (!mode_periodic && (|flags_nxt)) begin
                    state_nxt = ST_HELD;
                end
            end
            ST_HELD: begin
                if (mode_periodic) begin
                    if (ev_any) begin
                        state_nxt = ST_PULSE;
                        cnt_nxt   = CNT_LOAD;
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end else if (flags_nxt == '0) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_PULSE: begin
                if (mode_periodic && ev_any)
                    cnt_nxt = CNT_LOAD;
                else if (cnt == '0)
                    state_nxt = ST_IDLE;
                else
                    cnt_nxt = cnt - 1'b1;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        irq_n = (state == ST_IDLE);
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int PULSE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [6:0]        rtc_sec,
    input  logic [6:0]        rtc_min,
    input  logic [6:0]        rtc_hour,
    input  logic [6:0]        rtc_date,
    input  logic [6:0]        rtc_month,
    input  logic [6:0]        rtc_dow,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [1:0]        alm_flags,
    output logic              irq_n
);
    logic [NUM_FIELDS-1:0][6:0]                  rtc_vec;
    logic [NUM_ALARMS-1:0][NUM_FIELDS-1:0][7:0]  alarm_bytes;
    logic [CTRL_W-1:0]                           ctrl;
    logic [NUM_ALARMS-1:0]                       hit, set_evt, flags, flags_nxt;
    logic                                        mode_periodic, auto_clr;

    assign rtc_vec = {rtc_dow, rtc_month, rtc_date, rtc_hour, rtc_min, rtc_sec};
    assign mode_periodic = ctrl[BIT_PERIODIC];
    assign auto_clr      = ctrl[BIT_AUTOCLR];

    for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_cmp
        alarm_field_cmp u_cmp (
            .alarm_bytes (alarm_bytes[k]),
            .rtc_fields  (rtc_vec),
            .armed       (ctrl[k]),
            .hit         (hit[k])
        );
        assign set_evt[k] = tick && hit[k];
    end

    alarm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .set_evt     (set_evt),
        .rdata       (rdata),
        .alarm_bytes (alarm_bytes),
        .ctrl        (ctrl),
        .flags       (flags),
        .flags_nxt   (flags_nxt)
    );

    alarm_irq_fsm #(.PULSE_W(PULSE_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_periodic (mode_periodic),
        .ev_any        (|set_evt),
        .flags_nxt     (flags_nxt),
        .irq_n         (irq_n)
    );

    assign alm_flags = flags;
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
    import rtc_alarm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        wdata_lo,
    input logic [1:0]        alm_flags,
    input logic              irq_n,
    input logic              mode_periodic,
    input logic              auto_clr
);
    logic at_stat;
    assign at_stat = (addr == ADDR_W'(REG_STAT));

    assert_flag0_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flags[0]) |-> $past(tick));

    assert_flag1_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_flags[1]) |-> $past(tick));

    assert_single_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_periodic && $past(!mode_periodic) && (|alm_flags)) |-> !irq_n);

    assert_write_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && at_stat && !wdata_lo[0] && !tick) |-> !alm_flags[0]);

    assert_auto_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && at_stat && auto_clr && !tick) |-> (alm_flags == 2'b00));

    assert_pulse_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_periodic && $past(mode_periodic) && $fell(irq_n)) |-> $past(tick));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .addr          (addr),
    .wdata_lo      (wdata[1:0]),
    .alm_flags     (alm_flags),
    .irq_n         (irq_n),
    .mode_periodic (mode_periodic),
    .auto_clr      (auto_clr)
);

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] alm_flags;
    logic irq_n;
    logic [5:0][6:0] rv = '0;
    logic [5:0][7:0] a0, a1;
    logic [1:0] exp_flags;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    rtc_alarm_match #(.ADDR_W(4), .PULSE_W(PW)) u_rtc_alarm_match (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .rtc_sec(rv[0]), .rtc_min(rv[1]), .rtc_hour(rv[2]),
        .rtc_date(rv[3]), .rtc_month(rv[4]), .rtc_dow(rv[5]),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .alm_flags(alm_flags), .irq_n(irq_n)
    );

    function automatic logic ref_match(input logic [5:0][7:0] a, input logic armed,
                                       input logic [5:0][6:0] r);
        logic any = 1'b0, ok = 1'b1;
        for (int f = 0; f < 6; f++) begin
            if (a[f][7]) begin
                any = 1'b1;
                if (a[f][6:0] != r[f]) ok = 1'b0;
            end
        end
        return armed && any && ok;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        addr = 4'(a); wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_stat();
        addr = 4'd13; rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic load_alarms();
        for (int f = 0; f < 6; f++) wr(f, a0[f]);
        for (int f = 0; f < 6; f++) wr(6 + f, a1[f]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lows;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 flags at reset", alm_flags, 0);
        chk("R1 irq_n at reset", irq_n, 1);
        for (int a = 0; a < 16; a++) begin
            addr = 4'(a); #1;
            chk("R1 register reads zero in reset", rdata, 0);
        end
        rst_n = 1'b1;
        step();

        // R2: register map readback
        for (int a = 0; a < 12; a++) wr(a, 8'(8'h11 * a + 3));
        wr(12, 8'hF3);
        for (int a = 0; a < 12; a++) begin
            addr = 4'(a); #1;
            chk("R2 alarm byte readback", rdata, 8'(8'h11 * a + 3));
        end
        addr = 4'd12; #1; chk("R2 control keeps bits 3:0 only", rdata, 8'h03);
        addr = 4'd14; #1; chk("R2 unused address 14", rdata, 0);
        addr = 4'd15; #1; chk("R2 unused address 15", rdata, 0);

        // R3: 11:30 on January 1, seconds and weekday don't care
        a0 = '{8'h00, 8'h81, 8'h81, 8'h91, 8'hB0, 8'h00};
        a1 = '0;
        load_alarms();
        wr(12, 8'h01);
        rv = '{7'h00, 7'h01, 7'h01, 7'h11, 7'h29, 7'h59};
        pulse_tick();
        chk("R3 no flag at 11:29:59", alm_flags, 0);
        chk("R5 irq high without flag", irq_n, 1);
        rv = '{7'h03, 7'h01, 7'h01, 7'h11, 7'h30, 7'h00};
        step();
        chk("R3 equal fields without tick ignored", alm_flags, 0);
        pulse_tick();
        chk("R3 flag0 set on rollover into minute 30", alm_flags, 1);
        chk("R5 irq low with flag0", irq_n, 0);

        // R6: writing ones keeps flags and never sets
        wr(13, 8'hFF);
        chk("R6 write ones keeps flag0", alm_flags, 1);
        wr(13, 8'h00);
        chk("R6 write zero clears flag0", alm_flags, 0);
        chk("R5 irq high after clear", irq_n, 1);

        // R4: disarmed alarm and armed alarm without enables
        wr(12, 8'h00);
        pulse_tick();
        chk("R4 disarmed alarm ignored", alm_flags, 0);
        a1 = '0;
        a1[1] = 8'h30;
        wr(12, 8'h02);
        for (int f = 0; f < 6; f++) wr(6 + f, a1[f]);
        pulse_tick();
        chk("R4 no field enables ignored", alm_flags, 0);

        // R5: both flags, IRQ waits for both to clear
        a1[1] = 8'hB0;
        wr(7, a1[1]);
        wr(12, 8'h03);
        pulse_tick();
        chk("R5 both flags set", alm_flags, 3);
        wr(13, 8'h02);
        chk("R5 flag0 cleared", alm_flags, 2);
        chk("R5 irq stays low on flag1", irq_n, 0);
        wr(13, 8'h00);
        chk("R5 irq high once both clear", irq_n, 1);

        // R7: auto-clear on status read
        pulse_tick();
        rd_stat();
        chk("R7 read without auto-clear keeps flags", alm_flags, 3);
        wr(12, 8'h0B);
        rd_stat();
        chk("R7 auto-clear on read", alm_flags, 0);
        chk("R7 irq high after auto-clear", irq_n, 1);

        // R8: match in same cycle as clear
        pulse_tick();
        addr = 4'd13; wdata = 8'h00; wr_en = 1'b1; tick = 1'b1;
        step();
        wr_en = 1'b0; tick = 1'b0;
        chk("R8 set wins over write clear", alm_flags, 3);
        addr = 4'd13; rd_en = 1'b1; tick = 1'b1;
        step();
        rd_en = 1'b0; tick = 1'b0;
        chk("R8 set wins over auto-clear", alm_flags, 3);
        rd_stat();

        // R9: periodic pulse width, flags ignored, restart
        wr(12, 8'h05);
        chk("R9 idle high in periodic mode", irq_n, 1);
        pulse_tick();
        chk("R9 flag set in periodic mode", alm_flags, 1);
        lows = 0;
        while (irq_n == 1'b0 && lows < 50) begin lows++; step(); end
        chk("R9 pulse width with flag still set", lows, PW);
        pulse_tick();
        step();
        pulse_tick();
        lows = 2;
        while (irq_n == 1'b0 && lows < 50) begin lows++; step(); end
        chk("R9 restarted pulse width", lows, PW + 2);
        wr(12, 8'h00);
        wr(13, 8'h00);

        // R3 random: single-event mode against the reference function
        wr(12, 8'h03);
        for (int it = 0; it < 150; it++) begin
            for (int f = 0; f < 6; f++) begin
                rv[f] = 7'($urandom_range(0, 2));
                a0[f] = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 2))};
                a1[f] = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 2))};
            end
            load_alarms();
            exp_flags = {ref_match(a1, 1'b1, rv), ref_match(a0, 1'b1, rv)};
            pulse_tick();
            chk("R3 random match flags", alm_flags, exp_flags);
            chk("R5 random irq level", irq_n, exp_flags == 2'b00);
            wr(13, 8'h00);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule